// File: doc/BRIEF.md
# Encoded Level Interrupt Arbiter

This block sits between two external priority encoders and the CPU core. Each encoder drives a 4-bit active-low code on a level bus. A code of zero is the most urgent request and the all-ones code means idle. The block turns each code into a priority level and picks the more urgent of the two. It then compares the winner with the 4-bit interrupt mask held in the processor status register. When the winner is strictly above the mask, it raises a registered request toward the core and reports the winning level with it.

The second bus is optional. It takes part only when two control-register bits are both set: the level-input mode bit and the second-bus enable bit. Both bus inputs come from outside the clock domain, so each one passes through a two-stage synchronizer. A stability filter then accepts a new code only after two equal consecutive samples, which removes short glitches while an encoder switches between codes. The block also raises a wake indication during standby, but only when the low-speed 32 kHz oscillator is the selected clock source.

Top module: `lvl_irq_arbiter`

## Requirements
- R1: A bus code c decodes to priority level 15 − c. Code 4'b0000 is level 15, and code 4'b1111 is level 0, meaning no request.
- R2: Bus B counts only when `level_mode_en` and `bus_b_en` are both 1. Otherwise it is treated as the idle code.
- R3: The winning level is the larger of the two decoded levels. When the two levels are equal, bus A is reported as the source.
- R4: `irq_src_b` is 1 only while a request is raised and bus B's level is strictly greater than bus A's level.
- R5: `irq_req` is 1 only when the winning level is strictly greater than `irq_mask`. `irq_level` carries the winning level while `irq_req` is 1 and is 0 otherwise.
- R6: Requests are level-sensitive. `irq_req` stays 1 for as long as a qualifying code is held on a bus, and it falls once the bus returns to idle.
- R7: `wake` is 1 only when a request is accepted, `standby` is 1 and `slow_osc_sel` is 1.
- R8: A bus code held constant appears on the outputs at the fifth rising edge after it is applied. Changes on `irq_mask`, the enable bits, `standby` and `slow_osc_sel` appear at the next rising edge.
- R9: A bus code present for only one clock cycle has no effect on the outputs.
- R10: After a synchronous active-high reset, `irq_req`, `irq_level`, `irq_src_b` and `wake` are 0, and both buses behave as idle until new codes pass the filter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_a_n | input | 4 | Active-low encoded level, bus A |
| bus_b_n | input | 4 | Active-low encoded level, bus B |
| level_mode_en | input | 1 | Control bit: level-input mode |
| bus_b_en | input | 1 | Control bit: bus B enable |
| irq_mask | input | 4 | Interrupt mask from the status register |
| standby | input | 1 | Core is in standby |
| slow_osc_sel | input | 1 | Low-speed 32 kHz oscillator in use |
| irq_req | output | 1 | Registered interrupt request |
| irq_level | output | 4 | Accepted level, 0 when there is no request |
| irq_src_b | output | 1 | Winning request came from bus B |
| wake | output | 1 | Wake request out of standby |

## Verification
The assertions take for granted that the bus inputs carry the idle code while reset is held. The filter property looks back several cycles, and those cycles must not hold stale non-idle values. The bench drives the idle code throughout reset. It changes the buses, mask and control bits only on falling edges. Before each comparison it holds every code long enough to pass the synchronizer and the filter. The glitch case is the one place where a code is deliberately held for a single cycle.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
  localparam int LVL_W = 4;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t CODE_IDLE = '1;
endpackage

// File: rtl/lvl_sync_filter.sv
module lvl_sync_filter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam logic [W-1:0] IDLE = '1;

  logic [W-1:0] s1, s2, s3;

  // two synchronizer flops, then one flop holding the previous sample
  always_ff @(posedge clk) begin
    if (rst) begin
      s1   <= IDLE;
      s2   <= IDLE;
      s3   <= IDLE;
      dout <= IDLE;
    end else begin
      s1 <= din;
      s2 <= s1;
      s3 <= s2;
      if (s2 == s3) dout <= s2;
    end
  end

  // R9: filtered code changes only after two equal input samples
  p_stable_before_change_r9: assert property (@(posedge clk) disable iff (rst)
    (dout != $past(dout)) |-> ($past(din, 3) == $past(din, 4)));
endmodule

// File: rtl/lvl_pick.sv
module lvl_pick #(
  parameter int W = 4
) (
  input  logic [W-1:0] code_a,
  input  logic [W-1:0] code_b,
  input  logic         b_on,
  output logic [W-1:0] win_level,
  output logic         win_b
);
  logic [W-1:0] lvl_a, lvl_b;

  // all-ones minus code equals bitwise inversion
  always_comb begin
    lvl_a = ~code_a;
    lvl_b = b_on ? ~code_b : '0;
    win_b = (lvl_b > lvl_a);
    win_level = win_b ? lvl_b : lvl_a;
  end
endmodule

// File: rtl/lvl_irq_arbiter.sv
module lvl_irq_arbiter
  import lvl_irq_pkg::*;
#(
  parameter int W = LVL_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] bus_a_n,
  input  logic [W-1:0] bus_b_n,
  input  logic         level_mode_en,
  input  logic         bus_b_en,
  input  logic [W-1:0] irq_mask,
  input  logic         standby,
  input  logic         slow_osc_sel,
  output logic         irq_req,
  output logic [W-1:0] irq_level,
  output logic         irq_src_b,
  output logic         wake
);
  localparam int NBUS = 2;

  logic [W-1:0] raw   [NBUS];
  logic [W-1:0] clean [NBUS];
  logic [W-1:0] win_level;
  logic         win_b;
  logic         b_on;
  logic         accept;

  assign raw[0] = bus_a_n;
  assign raw[1] = bus_b_n;

  for (genvar g = 0; g < NBUS; g++) begin : g_bus
    lvl_sync_filter #(.W(W)) filt_i (
      .clk  (clk),
      .rst  (rst),
      .din  (raw[g]),
      .dout (clean[g])
    );
  end

  assign b_on = level_mode_en & bus_b_en;

  lvl_pick #(.W(W)) pick_i (
    .code_a    (clean[0]),
    .code_b    (clean[1]),
    .b_on      (b_on),
    .win_level (win_level),
    .win_b     (win_b)
  );

  assign accept = (win_level > irq_mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req   <= 1'b0;
      irq_level <= '0;
      irq_src_b <= 1'b0;
      wake      <= 1'b0;
    end else begin
      irq_req   <= accept;
      irq_level <= accept ? win_level : '0;
      irq_src_b <= accept & win_b;
      wake      <= accept & standby & slow_osc_sel;
    end
  end

  // R5: a raised request is above the mask sampled at its edge
  p_req_above_mask_r5: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_level > $past(irq_mask)));
  // R5: no request means level reads zero
  p_idle_level_zero_r5: assert property (@(posedge clk) disable iff (rst)
    !irq_req |-> (irq_level == '0));
  // R7: wake only with a request, standby and slow oscillator
  p_wake_gated_r7: assert property (@(posedge clk) disable iff (rst)
    wake |-> (irq_req && $past(standby) && $past(slow_osc_sel)));
  // R2: bus B can be the source only when both control bits were set
  p_src_b_gated_r2: assert property (@(posedge clk) disable iff (rst)
    irq_src_b |-> (irq_req && $past(level_mode_en) && $past(bus_b_en)));
endmodule

// File: tb/lvl_irq_arbiter_tb.sv
module lvl_irq_arbiter_tb_top;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] bus_a_n, bus_b_n, irq_mask;
  logic         level_mode_en, bus_b_en, standby, slow_osc_sel;
  logic         irq_req, irq_src_b, wake;
  logic [W-1:0] irq_level;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  lvl_irq_arbiter #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .bus_a_n(bus_a_n), .bus_b_n(bus_b_n),
    .level_mode_en(level_mode_en), .bus_b_en(bus_b_en), .irq_mask(irq_mask),
    .standby(standby), .slow_osc_sel(slow_osc_sel), .irq_req(irq_req),
    .irq_level(irq_level), .irq_src_b(irq_src_b), .wake(wake)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check_all(input int a, input int b, input int en, input int m,
                           input int sb, input int osc);
    int la, lb, win, acc;
    la  = 15 - a;
    lb  = (en == 3) ? 15 - b : 0;
    win = (lb > la) ? lb : la;
    acc = (win > m) ? 1 : 0;
    chk("R5 req",   int'(irq_req),   acc);
    chk("R1 R3 level", int'(irq_level), acc ? win : 0);
    chk("R2 R4 src", int'(irq_src_b), (acc && lb > la) ? 1 : 0);
    chk("R7 wake",  int'(wake),      (acc && sb && osc) ? 1 : 0);
  endtask

  initial begin
    rst = 1'b1; bus_a_n = '1; bus_b_n = '1; irq_mask = '0;
    level_mode_en = 1'b0; bus_b_en = 1'b0; standby = 1'b0; slow_osc_sel = 1'b0;
    step(4);
    rst = 1'b0;
    // R10: reset state
    chk("R10 req", int'(irq_req), 0);
    chk("R10 level", int'(irq_level), 0);
    chk("R10 src", int'(irq_src_b), 0);
    chk("R10 wake", int'(wake), 0);

    // R8: latency of a bus change, five rising edges
    bus_a_n = 4'd3;
    step(4);
    chk("R8 not yet", int'(irq_req), 0);
    step(1);
    chk("R8 arrived", int'(irq_req), 1);
    chk("R8 level", int'(irq_level), 12);
    // R6: held code keeps the request up
    step(10);
    chk("R6 held", int'(irq_req), 1);
    // R8: mask change takes effect at next edge
    irq_mask = 4'd12;
    step(1);
    chk("R8 mask", int'(irq_req), 0);
    irq_mask = 4'd0;
    step(1);
    // R6: back to idle drops the request
    bus_a_n = '1;
    step(5);
    chk("R6 drop", int'(irq_req), 0);

    // R9: single-cycle glitch ignored
    bus_a_n = 4'd0;
    step(1);
    bus_a_n = '1;
    for (int i = 0; i < 8; i++) begin
      step(1);
      chk("R9 glitch", int'(irq_req), 0);
    end

    // exhaustive sweep: enables x codes x mask
    for (int en = 0; en < 4; en++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          level_mode_en = en[0];
          bus_b_en = en[1];
          bus_a_n = a[3:0];
          bus_b_n = b[3:0];
          step(6);
          for (int m = 0; m < 16; m++) begin
            irq_mask = m[3:0];
            standby = m[0] ^ a[0];
            slow_osc_sel = m[1] ^ b[0];
            step(1);
            check_all(a, b, en, m, int'(standby), int'(slow_osc_sel));
          end
        end
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule